// File: doc/BRIEF.md
# HDLC loopback and reset controller

This block surrounds an HDLC transmitter, an HDLC receiver and their byte FIFOs, and provides their test and recovery controls. A small register bank, written over a byte-wide bus with a one-cycle write strobe, holds the receive and transmit enables, the station address byte used for address matching, and a test word. The test word has a sticky soft-reset bit and two loopback selects.

While soft reset is set, the controller holds the HDLC datapath and its configuration in reset. Soft reset does not clear itself. With receive-to-transmit loopback on, the controller copies each received payload byte into the transmit FIFO write port. Each copied byte carries a tag that marks a middle byte, the end of a good packet, or the end of a bad packet. Flag and CRC bytes are not copied. A processor write to the transmit FIFO that collides with a loopback copy is delayed by one slot. With transmit-to-receive loopback on, and both enables set, the transmitter's serial output takes the place of the external receive line.

Top module: `hdlc_lpbk_ctrl`

## Requirements
- R1: After global reset, all control bits and the address byte are 0, `hdlc_rst_o` is 0, and no transmit FIFO write is issued.
- R2: A write to address 0 sets the receive enable (bit 0) and the transmit enable (bit 1). A write to address 2 loads the address byte. A write to address 1 loads the test word: bit 0 is soft reset, bit 1 is receive-to-transmit loopback, bit 2 is transmit-to-receive loopback. Each write shows on the outputs after the next clock edge.
- R3: While soft reset is 1, `hdlc_rst_o` is 1. The enables, the address byte and both loopback bits read 0, writes to them are ignored, and no loopback copy is made.
- R4: The soft-reset bit stays 1 until software writes 0 to test-word bit 0 or global reset is applied.
- R5: With receive-to-transmit loopback on, a received payload byte appears on the transmit FIFO write port one cycle later. Its tag is 00 for a middle byte, 01 for the last byte of a good packet and 10 for the last byte of a bad packet. The bad flag is ignored on bytes that are not last.
- R6: Bytes marked as control (flag or CRC) are never copied, whatever their end or bad flags.
- R7: With receive-to-transmit loopback off, received bytes cause no transmit FIFO write.
- R8: `rx_ser_o` follows `tx_ser_i` one cycle later when transmit-to-receive loopback and both enables are set. Otherwise it follows `ext_rx_ser_i` one cycle later.
- R9: When a loopback copy and a processor write occur in the same cycle, the loopback byte is written first. The processor byte is written in the next cycle, and `cpu_tx_busy_o` is 1 for that one cycle.
- R10: A processor write with no loopback copy in the same cycle appears on the transmit FIFO write port one cycle later, with its own data and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| hdlc_rst_o | output | 1 | Soft reset to the HDLC datapath |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| match_addr_o | output | DATA_W | Station address byte for the receiver |
| rx_byte_vld_i | input | 1 | Receiver delivers a byte this cycle |
| rx_byte_i | input | DATA_W | Received byte |
| rx_byte_ctl_i | input | 1 | Byte is a flag or a CRC byte |
| rx_byte_eop_i | input | 1 | Byte is the last byte of a packet |
| rx_byte_bad_i | input | 1 | Packet ended with a CRC error or an abort |
| cpu_tx_wr_i | input | 1 | Processor write to the transmit FIFO |
| cpu_tx_data_i | input | DATA_W | Processor byte |
| cpu_tx_tag_i | input | 2 | Processor byte tag |
| cpu_tx_busy_o | output | 1 | A delayed processor byte is pending |
| txf_wr_o | output | 1 | Transmit FIFO write |
| txf_data_o | output | DATA_W | Transmit FIFO byte |
| txf_tag_o | output | 2 | Transmit FIFO tag |
| tx_ser_i | input | 1 | Transmitter serial output |
| ext_rx_ser_i | input | 1 | External receive serial line |
| rx_ser_o | output | 1 | Serial stream to the receiver input |

## Verification
The assertions assume that the processor never writes to the transmit FIFO while `cpu_tx_busy_o` is 1. They also assume that loopback copies do not arrive on every cycle, so a delayed processor byte always finds a free slot. The bench keeps to both: every collision it creates is followed by idle cycles, and no processor write is issued during the busy cycle. The receiver flags (control, end, bad) are taken as meaningful only when the byte-valid input is set. The table-driven stimulus also drives them with valid low, to show that nothing is copied in that case.

// File: rtl/hdlc_lpbk_pkg.sv
package hdlc_lpbk_pkg;
  // register addresses
  localparam int unsigned ADR_CTRL  = 0;
  localparam int unsigned ADR_TEST  = 1;
  localparam int unsigned ADR_MATCH = 2;
  // control word bits
  localparam int unsigned BIT_RXEN = 0;
  localparam int unsigned BIT_TXEN = 1;
  // test word bits
  localparam int unsigned BIT_SRST = 0;
  localparam int unsigned BIT_R2T  = 1;
  localparam int unsigned BIT_T2R  = 2;
  // transmit FIFO tags
  localparam logic [1:0] TAG_MID      = 2'b00;
  localparam logic [1:0] TAG_GOOD_END = 2'b01;
  localparam logic [1:0] TAG_BAD_END  = 2'b10;
endpackage

// File: rtl/hdlc_lpbk_regs.sv
module hdlc_lpbk_regs
  import hdlc_lpbk_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              srst_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              r2t_o,
  output logic              t2r_o,
  output logic [DATA_W-1:0] match_o
);
  logic wr_ctrl, wr_test, wr_match, clr;
  logic srst_q, rx_en_q, tx_en_q, r2t_q, t2r_q;
  logic [DATA_W-1:0] match_q;

  assign wr_ctrl  = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_CTRL));
  assign wr_test  = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_TEST));
  assign wr_match = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_MATCH));
  // held clear while soft reset is active or being set
  assign clr = srst_q || (wr_test && reg_wdata_i[BIT_SRST]);

  // the soft-reset bit is outside its own reset domain
  always_ff @(posedge clk) begin
    if (rst)          srst_q <= 1'b0;
    else if (wr_test) srst_q <= reg_wdata_i[BIT_SRST];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      r2t_q   <= 1'b0;
      t2r_q   <= 1'b0;
      match_q <= '0;
    end else begin
      if (wr_ctrl) begin
        rx_en_q <= reg_wdata_i[BIT_RXEN];
        tx_en_q <= reg_wdata_i[BIT_TXEN];
      end
      if (wr_test) begin
        r2t_q <= reg_wdata_i[BIT_R2T];
        t2r_q <= reg_wdata_i[BIT_T2R];
      end
      if (wr_match) match_q <= reg_wdata_i;
    end
  end

  assign srst_o  = srst_q;
  assign rx_en_o = rx_en_q;
  assign tx_en_o = tx_en_q;
  assign r2t_o   = r2t_q;
  assign t2r_o   = t2r_q;
  assign match_o = match_q;

  assert_srst_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (srst_q && !wr_test) |=> srst_q);

  assert_held_clear_R3: assert property (@(posedge clk) disable iff (rst)
    srst_q |-> (!rx_en_q && !tx_en_q && !r2t_q && !t2r_q && match_q == '0));
endmodule

// File: rtl/hdlc_lpbk_steer.sv
module hdlc_lpbk_steer
  import hdlc_lpbk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_i,
  input  logic              r2t_i,
  input  logic              rx_vld_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_ctl_i,
  input  logic              rx_eop_i,
  input  logic              rx_bad_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic [1:0]        cpu_tag_i,
  output logic              cpu_busy_o,
  output logic              txf_wr_o,
  output logic [DATA_W-1:0] txf_data_o,
  output logic [1:0]        txf_tag_o
);
  logic              loop_go;
  logic [1:0]        loop_tag;
  logic              txf_wr_q, pend_q;
  logic [DATA_W-1:0] txf_data_q, pend_data_q;
  logic [1:0]        txf_tag_q, pend_tag_q;

  assign loop_go  = r2t_i && rx_vld_i && !rx_ctl_i && !hold_i;
  assign loop_tag = !rx_eop_i ? TAG_MID : (rx_bad_i ? TAG_BAD_END : TAG_GOOD_END);

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      txf_wr_q    <= 1'b0;
      txf_data_q  <= '0;
      txf_tag_q   <= TAG_MID;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
      pend_tag_q  <= TAG_MID;
    end else begin
      txf_wr_q <= loop_go || pend_q || cpu_wr_i;
      if (loop_go) begin
        txf_data_q <= rx_byte_i;
        txf_tag_q  <= loop_tag;
        if (cpu_wr_i) begin
          pend_q      <= 1'b1;
          pend_data_q <= cpu_data_i;
          pend_tag_q  <= cpu_tag_i;
        end
      end else if (pend_q) begin
        txf_data_q <= pend_data_q;
        txf_tag_q  <= pend_tag_q;
        pend_q     <= 1'b0;
      end else if (cpu_wr_i) begin
        txf_data_q <= cpu_data_i;
        txf_tag_q  <= cpu_tag_i;
      end
    end
  end

  assign cpu_busy_o = pend_q;
  assign txf_wr_o   = txf_wr_q;
  assign txf_data_o = txf_data_q;
  assign txf_tag_o  = txf_tag_q;

  assert_ctl_not_looped_R6: assert property (@(posedge clk) disable iff (rst || hold_i)
    (rx_vld_i && rx_ctl_i && !cpu_wr_i && !pend_q) |=> !txf_wr_q);

  assert_loop_first_R9: assert property (@(posedge clk) disable iff (rst || hold_i)
    (r2t_i && rx_vld_i && !rx_ctl_i && cpu_wr_i) |=>
      (txf_wr_q && pend_q && txf_data_q == $past(rx_byte_i)));

  assert_pend_drains_R9: assert property (@(posedge clk) disable iff (rst || hold_i)
    (pend_q && !(r2t_i && rx_vld_i && !rx_ctl_i)) |=> (!pend_q && txf_wr_q));
endmodule

// File: rtl/hdlc_lpbk_sermux.sv
module hdlc_lpbk_sermux (
  input  logic clk,
  input  logic rst,
  input  logic t2r_i,
  input  logic rx_en_i,
  input  logic tx_en_i,
  input  logic tx_ser_i,
  input  logic ext_ser_i,
  output logic rx_ser_o
);
  logic sel, ser_q;

  assign sel = t2r_i && rx_en_i && tx_en_i;

  always_ff @(posedge clk) begin
    if (rst) ser_q <= 1'b0;
    else     ser_q <= sel ? tx_ser_i : ext_ser_i;
  end

  assign rx_ser_o = ser_q;

  assert_ext_path_R8: assert property (@(posedge clk) disable iff (rst)
    !(t2r_i && rx_en_i && tx_en_i) |=> (ser_q == $past(ext_ser_i)));

  assert_loop_path_R8: assert property (@(posedge clk) disable iff (rst)
    (t2r_i && rx_en_i && tx_en_i) |=> (ser_q == $past(tx_ser_i)));
endmodule

// File: rtl/hdlc_lpbk_ctrl.sv
module hdlc_lpbk_ctrl #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              hdlc_rst_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic [DATA_W-1:0] match_addr_o,
  input  logic              rx_byte_vld_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_byte_ctl_i,
  input  logic              rx_byte_eop_i,
  input  logic              rx_byte_bad_i,
  input  logic              cpu_tx_wr_i,
  input  logic [DATA_W-1:0] cpu_tx_data_i,
  input  logic [1:0]        cpu_tx_tag_i,
  output logic              cpu_tx_busy_o,
  output logic              txf_wr_o,
  output logic [DATA_W-1:0] txf_data_o,
  output logic [1:0]        txf_tag_o,
  input  logic              tx_ser_i,
  input  logic              ext_rx_ser_i,
  output logic              rx_ser_o
);
  logic srst, rx_en, tx_en, r2t, t2r;

  hdlc_lpbk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .srst_o(srst), .rx_en_o(rx_en), .tx_en_o(tx_en),
    .r2t_o(r2t), .t2r_o(t2r), .match_o(match_addr_o)
  );

  hdlc_lpbk_steer #(.DATA_W(DATA_W)) u_steer (
    .clk(clk), .rst(rst), .hold_i(srst), .r2t_i(r2t),
    .rx_vld_i(rx_byte_vld_i), .rx_byte_i(rx_byte_i), .rx_ctl_i(rx_byte_ctl_i),
    .rx_eop_i(rx_byte_eop_i), .rx_bad_i(rx_byte_bad_i),
    .cpu_wr_i(cpu_tx_wr_i), .cpu_data_i(cpu_tx_data_i), .cpu_tag_i(cpu_tx_tag_i),
    .cpu_busy_o(cpu_tx_busy_o), .txf_wr_o(txf_wr_o), .txf_data_o(txf_data_o),
    .txf_tag_o(txf_tag_o)
  );

  hdlc_lpbk_sermux u_mux (
    .clk(clk), .rst(rst), .t2r_i(t2r), .rx_en_i(rx_en), .tx_en_i(tx_en),
    .tx_ser_i(tx_ser_i), .ext_ser_i(ext_rx_ser_i), .rx_ser_o(rx_ser_o)
  );

  assign hdlc_rst_o = srst;
  assign rx_en_o    = rx_en;
  assign tx_en_o    = tx_en;
endmodule

// File: tb/tb_hdlc_lpbk_ctrl.sv
`timescale 1ns/1ps
module tb_hdlc_lpbk_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic hdlc_rst, rx_en, tx_en;
  logic [7:0] match_addr;
  logic rx_vld = 1'b0, rx_ctl = 1'b0, rx_eop = 1'b0, rx_bad = 1'b0;
  logic [7:0] rx_byte = '0;
  logic cpu_wr = 1'b0;
  logic [7:0] cpu_data = '0;
  logic [1:0] cpu_tag = '0;
  logic cpu_busy, txf_wr;
  logic [7:0] txf_data;
  logic [1:0] txf_tag;
  logic tx_ser = 1'b0, ext_ser = 1'b0, rx_ser;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hdlc_lpbk_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .hdlc_rst_o(hdlc_rst), .rx_en_o(rx_en),
    .tx_en_o(tx_en), .match_addr_o(match_addr), .rx_byte_vld_i(rx_vld),
    .rx_byte_i(rx_byte), .rx_byte_ctl_i(rx_ctl), .rx_byte_eop_i(rx_eop),
    .rx_byte_bad_i(rx_bad), .cpu_tx_wr_i(cpu_wr), .cpu_tx_data_i(cpu_data),
    .cpu_tx_tag_i(cpu_tag), .cpu_tx_busy_o(cpu_busy), .txf_wr_o(txf_wr),
    .txf_data_o(txf_data), .txf_tag_o(txf_tag), .tx_ser_i(tx_ser),
    .ext_rx_ser_i(ext_ser), .rx_ser_o(rx_ser)
  );

  // vector: {vld, ctl, eop, bad, data[7:0], exp_wr, exp_tag[1:0]}
  localparam int NV = 8;
  localparam logic [14:0] VEC [NV] = '{
    {4'b1000, 8'h11, 1'b1, 2'b00},  // R5 middle byte
    {4'b1100, 8'h7E, 1'b0, 2'b00},  // R6 flag
    {4'b1010, 8'h22, 1'b1, 2'b01},  // R5 good end
    {4'b1100, 8'hA5, 1'b0, 2'b00},  // R6 crc byte
    {4'b1011, 8'h33, 1'b1, 2'b10},  // R5 bad end
    {4'b0000, 8'h44, 1'b0, 2'b00},  // R5 not valid
    {4'b1001, 8'h55, 1'b1, 2'b00},  // R5 bad flag without end
    {4'b1111, 8'h66, 1'b0, 2'b00}   // R6 control with end
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rx_idle();
    rx_vld = 1'b0; rx_ctl = 1'b0; rx_eop = 1'b0; rx_bad = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 hdlc_rst", hdlc_rst, 0);
    check("R1 enables", {rx_en, tx_en}, 0);
    check("R1 match", match_addr, 0);
    check("R1 txf_wr", txf_wr, 0);
    check("R1 busy", cpu_busy, 0);

    // R2 register writes
    write_reg(2'd0, 8'h03);
    check("R2 enables", {rx_en, tx_en}, 2'b11);
    write_reg(2'd2, 8'h5A);
    check("R2 match", match_addr, 8'h5A);

    // R8 serial loop on with both enables
    write_reg(2'd1, 8'h04);
    tx_ser = 1'b1; ext_ser = 1'b0;
    @(negedge clk);
    check("R8 loop path 1", rx_ser, 1);
    tx_ser = 1'b0; ext_ser = 1'b1;
    @(negedge clk);
    check("R8 loop path 0", rx_ser, 0);
    write_reg(2'd0, 8'h01);
    tx_ser = 1'b1; ext_ser = 1'b0;
    @(negedge clk);
    check("R8 tx disabled uses external", rx_ser, 0);
    write_reg(2'd0, 8'h03);
    write_reg(2'd1, 8'h00);
    tx_ser = 1'b1; ext_ser = 1'b0;
    @(negedge clk);
    check("R8 loop bit off uses external", rx_ser, 0);

    // R7 receive loop off
    rx_vld = 1'b1; rx_byte = 8'h99; rx_eop = 1'b1;
    @(negedge clk);
    rx_idle();
    check("R7 no copy when off", txf_wr, 0);

    // R10 processor write alone
    cpu_wr = 1'b1; cpu_data = 8'h9C; cpu_tag = 2'b01;
    @(negedge clk);
    cpu_wr = 1'b0;
    check("R10 wr", txf_wr, 1);
    check("R10 data", txf_data, 8'h9C);
    check("R10 tag", txf_tag, 2'b01);

    // R5 / R6 table walk with receive loop on
    write_reg(2'd1, 8'h02);
    for (int i = 0; i < NV; i++) begin
      {rx_vld, rx_ctl, rx_eop, rx_bad} = VEC[i][14:11];
      rx_byte = VEC[i][10:3];
      @(negedge clk);
      check("R5/R6 vector wr", txf_wr, VEC[i][2]);
      if (VEC[i][2]) begin
        check("R5 vector data", txf_data, VEC[i][10:3]);
        check("R5 vector tag", txf_tag, VEC[i][1:0]);
      end
    end
    rx_idle();
    @(negedge clk);

    // R9 collision
    rx_vld = 1'b1; rx_byte = 8'h77; rx_eop = 1'b1; rx_bad = 1'b0;
    cpu_wr = 1'b1; cpu_data = 8'hC3; cpu_tag = 2'b00;
    @(negedge clk);
    rx_idle(); cpu_wr = 1'b0;
    check("R9 loop first wr", txf_wr, 1);
    check("R9 loop first data", txf_data, 8'h77);
    check("R9 loop first tag", txf_tag, 2'b01);
    check("R9 busy", cpu_busy, 1);
    @(negedge clk);
    check("R9 cpu second wr", txf_wr, 1);
    check("R9 cpu second data", txf_data, 8'hC3);
    check("R9 cpu second tag", txf_tag, 2'b00);
    check("R9 busy clear", cpu_busy, 0);
    @(negedge clk);
    check("R9 idle after", txf_wr, 0);

    // R3 / R4 soft reset
    write_reg(2'd1, 8'h07);
    check("R3 hdlc_rst on", hdlc_rst, 1);
    check("R3 enables cleared", {rx_en, tx_en}, 0);
    check("R3 match cleared", match_addr, 0);
    write_reg(2'd0, 8'h03);
    check("R3 ctrl write ignored", {rx_en, tx_en}, 0);
    write_reg(2'd2, 8'hA7);
    check("R3 match write ignored", match_addr, 0);
    rx_vld = 1'b1; rx_byte = 8'h12;
    @(negedge clk);
    rx_idle();
    check("R3 no loop copy", txf_wr, 0);
    repeat (10) @(negedge clk);
    check("R4 sticky", hdlc_rst, 1);
    write_reg(2'd1, 8'h00);
    check("R4 cleared by write", hdlc_rst, 0);
    check("R3 enables stay cleared", {rx_en, tx_en}, 0);
    rx_vld = 1'b1; rx_byte = 8'h12;
    @(negedge clk);
    rx_idle();
    check("R3 loop bit was cleared", txf_wr, 0);
    write_reg(2'd0, 8'h03);
    check("R2 ctrl writable again", {rx_en, tx_en}, 2'b11);

    // R4 global reset clears soft reset
    write_reg(2'd1, 8'h01);
    check("R4 set again", hdlc_rst, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 global reset clears", hdlc_rst, 0);
    check("R1 enables after reset", {rx_en, tx_en}, 0);

    finish_run();
  end
endmodule